// File: doc/BRIEF.md
# Split-Transaction Response Tag Tracker

This block sits on the initiator side of a request/response link whose two directions are fully decoupled. The initiator may post several requests back to back without waiting for any answer, and answers may come back any number of cycles later. The tracker records the context of every request it accepts: its tag, address and command. When a response arrives, the tracker finds the matching record, retires it and presents a completion that joins the stored context to the returned data.

Two matching disciplines are selected by the `tag_mode` pin. With `tag_mode` low, the link is ordered. Responses must come back in the order the requests were issued, and the tracker checks that each response tag equals the tag of the oldest outstanding request. With `tag_mode` high, each response is matched by its tag alone, so responses from different tags may overtake one another. A tag cannot be issued again while it is still outstanding. Two cases raise a one-cycle error code instead of a completion: a response with nothing to match, and a response out of order on the ordered link.

Top module: `stt_tracker`

## Requirements
- R1: After reset, `req_ready` and `rsp_ready` are high, `cpl_valid` is low and `err_code` is 2'b00.
- R2: No more than MAX_OUT requests are outstanding at once. With MAX_OUT outstanding, `req_ready` is low until a response retires one of them.
- R3: With `tag_mode` low, a response whose tag equals that of the oldest outstanding request retires that request. One clock edge after the response handshake, `cpl_valid` is high and `cpl_id`, `cpl_addr`, `cpl_cmd` carry the stored context, with `cpl_data` equal to the response data.
- R4: With `tag_mode` low, a response whose tag differs from the oldest outstanding tag still retires the oldest request. It produces no completion, and `err_code` reads 2'b10 for one cycle.
- R5: A response that has no outstanding request to match produces no completion and changes no tracked state, and `err_code` reads 2'b01 for one cycle. On the ordered link this means nothing is outstanding. With `tag_mode` high it means the response tag is not outstanding.
- R6: With `tag_mode` high, responses may return in any order. Each completion carries the address and command stored for the tag that the response names.
- R7: With `tag_mode` high, `req_ready` is low while the offered `req_id` is outstanding. It returns high after the response for that tag has been accepted.
- R8: A request and a response accepted on the same clock edge are both handled: the response is matched against the state before that edge, and the request is recorded.
- R9: While `cpl_valid` is high and `cpl_ready` is low, `rsp_ready` is low and every completion output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_mode | input | 1 | 0: ordered matching, 1: tag matching; change only with nothing outstanding |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_id | input | ID_W | Request tag |
| req_addr | input | ADDR_W | Request address |
| req_cmd | input | CMD_W | Request command type |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Response can be accepted |
| rsp_id | input | ID_W | Response tag |
| rsp_data | input | DATA_W | Response data |
| cpl_valid | output | 1 | Completion present |
| cpl_ready | input | 1 | Completion consumed |
| cpl_id | output | ID_W | Stored request tag |
| cpl_addr | output | ADDR_W | Stored request address |
| cpl_cmd | output | CMD_W | Stored request command |
| cpl_data | output | DATA_W | Returned data |
| err_code | output | 2 | 00 none, 01 unmatched response, 10 order violation; valid for one cycle |

## Verification
A completion or an error code appears one rising edge after the response handshake that causes it. A request changes `req_ready` one edge after its handshake. `rsp_ready` follows `cpl_ready` within the same cycle. The bench drives inputs just after a falling edge and compares both ready outputs against its reference model before the next rising edge. After the model has applied that edge's handshakes, the bench compares the completion and error outputs at the following falling edge, so every check lands in the cycle where the result is due.

// File: rtl/stt_pkg.sv
package stt_pkg;

  typedef enum logic [1:0] {
    STT_ERR_NONE   = 2'b00,
    STT_ERR_ORPHAN = 2'b01,
    STT_ERR_ORDER  = 2'b10
  } stt_err_e;

endpackage

// File: rtl/stt_order_ctl.sv
module stt_order_ctl #(
  parameter int ID_W    = 3,
  parameter int MAX_OUT = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  output logic [ID_W-1:0] head,
  output logic [ID_W-1:0] tail,
  output logic            full,
  output logic            empty
);

  localparam int CNT_W = $clog2(MAX_OUT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ID_W-1:0]  head_q, head_d, tail_q, tail_d;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (push) tail_d = tail_q + ID_W'(1);
    if (pop)  head_d = head_q + ID_W'(1);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (push || pop) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign full  = (cnt_q == CNT_MAX);
  assign empty = (cnt_q == '0);

  // R2: the request gate never lets a push through at the limit
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R5: a retire only happens when something is outstanding
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R2: the limit is never exceeded
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

endmodule

// File: rtl/stt_ctx_store.sv
module stt_ctx_store #(
  parameter int ID_W   = 3,
  parameter int ADDR_W = 16,
  parameter int CMD_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ID_W-1:0]       wr_slot,
  input  logic [ID_W-1:0]       wr_id,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [CMD_W-1:0]      wr_cmd,
  input  logic                  clr_en,
  input  logic [ID_W-1:0]       clr_slot,
  input  logic [ID_W-1:0]       rd_slot,
  output logic [ID_W-1:0]       rd_id,
  output logic [ADDR_W-1:0]     rd_addr,
  output logic [CMD_W-1:0]      rd_cmd,
  output logic [(1<<ID_W)-1:0]  busy
);

  localparam int SLOTS = 1 << ID_W;

  logic [ID_W-1:0]   id_all   [SLOTS];
  logic [ADDR_W-1:0] addr_all [SLOTS];
  logic [CMD_W-1:0]  cmd_all  [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic              set_hit, clr_hit, busy_en, busy_d, busy_r;
    logic [ID_W-1:0]   id_r;
    logic [ADDR_W-1:0] addr_r;
    logic [CMD_W-1:0]  cmd_r;

    always_comb begin
      set_hit = wr_en  && (wr_slot  == ID_W'(s));
      clr_hit = clr_en && (clr_slot == ID_W'(s));
      busy_en = set_hit || clr_hit;
      busy_d  = set_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       busy_r <= 1'b0;
      else if (busy_en) busy_r <= busy_d;
    end

    always_ff @(posedge clk) begin
      if (set_hit) begin
        id_r   <= wr_id;
        addr_r <= wr_addr;
        cmd_r  <= wr_cmd;
      end
    end

    assign busy[s]     = busy_r;
    assign id_all[s]   = id_r;
    assign addr_all[s] = addr_r;
    assign cmd_all[s]  = cmd_r;
  end

  assign rd_id   = id_all[rd_slot];
  assign rd_addr = addr_all[rd_slot];
  assign rd_cmd  = cmd_all[rd_slot];

  // R7: a live slot is never overwritten
  p_no_reissue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !busy[wr_slot]);

  // R8: a clear always targets a live slot different from the one written
  p_clr_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && wr_en) |-> (busy[clr_slot] && (clr_slot != wr_slot)));

endmodule

// File: rtl/stt_cpl_stage.sv
module stt_cpl_stage #(
  parameter int ID_W   = 3,
  parameter int ADDR_W = 16,
  parameter int CMD_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_fire,
  input  logic                in_hit,
  input  logic [1:0]          in_err,
  input  logic [ID_W-1:0]     in_id,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [CMD_W-1:0]    in_cmd,
  input  logic [DATA_W-1:0]   in_data,
  output logic                in_ready,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [ID_W-1:0]     out_id,
  output logic [ADDR_W-1:0]   out_addr,
  output logic [CMD_W-1:0]    out_cmd,
  output logic [DATA_W-1:0]   out_data,
  output logic [1:0]          out_err
);

  logic              vld_q, vld_d;
  logic [1:0]        err_q, err_d;
  logic              load;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] data_q;

  assign in_ready = !vld_q || out_ready;

  always_comb begin
    vld_d = vld_q;
    err_d = stt_pkg::STT_ERR_NONE;
    load  = in_fire && in_hit;
    if (in_fire) begin
      vld_d = in_hit;
      err_d = in_err;
    end else if (out_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      err_q <= stt_pkg::STT_ERR_NONE;
    end else begin
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      id_q   <= in_id;
      addr_q <= in_addr;
      cmd_q  <= in_cmd;
      data_q <= in_data;
    end
  end

  assign out_valid = vld_q;
  assign out_err   = err_q;
  assign out_id    = id_q;
  assign out_addr  = addr_q;
  assign out_cmd   = cmd_q;
  assign out_data  = data_q;

  // R9: a stalled completion keeps its contents
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_id) &&
      $stable(out_addr) && $stable(out_cmd) && $stable(out_data)));

  // R4: an error cycle never carries a completion
  p_err_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_err != stt_pkg::STT_ERR_NONE) |-> !out_valid);

  // R5: an error code lasts a single cycle while no response is taken
  p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_err != stt_pkg::STT_ERR_NONE) && !in_fire) |=> (out_err == stt_pkg::STT_ERR_NONE));

endmodule

// File: rtl/stt_tracker.sv
module stt_tracker #(
  parameter int ID_W    = 3,
  parameter int ADDR_W  = 16,
  parameter int CMD_W   = 2,
  parameter int DATA_W  = 32,
  parameter int MAX_OUT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tag_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [ID_W-1:0]   rsp_id,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [ID_W-1:0]   cpl_id,
  output logic [ADDR_W-1:0] cpl_addr,
  output logic [CMD_W-1:0]  cpl_cmd,
  output logic [DATA_W-1:0] cpl_data,
  output logic [1:0]        err_code
);

  localparam int SLOTS = 1 << ID_W;

  logic             req_fire, rsp_fire, present, match, retire;
  logic [1:0]       err_now;
  logic [ID_W-1:0]  head, tail, wr_slot, rd_slot;
  logic             full, empty;
  logic [SLOTS-1:0] busy;
  logic [ID_W-1:0]  rd_id;
  logic [ADDR_W-1:0] rd_addr;
  logic [CMD_W-1:0] rd_cmd;

  always_comb begin
    req_ready = !full && !(tag_mode && busy[req_id]);
    req_fire  = req_valid && req_ready;
    rsp_fire  = rsp_valid && rsp_ready;
    wr_slot   = tag_mode ? req_id : tail;
    rd_slot   = tag_mode ? rsp_id : head;
    if (tag_mode) begin
      present = busy[rsp_id];
      match   = present;
    end else begin
      present = !empty;
      match   = present && (rd_id == rsp_id);
    end
    if (!present)    err_now = stt_pkg::STT_ERR_ORPHAN;
    else if (!match) err_now = stt_pkg::STT_ERR_ORDER;
    else             err_now = stt_pkg::STT_ERR_NONE;
    retire = rsp_fire && present;
  end

  stt_order_ctl #(.ID_W(ID_W), .MAX_OUT(MAX_OUT)) u_order (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (req_fire),
    .pop   (retire),
    .head  (head),
    .tail  (tail),
    .full  (full),
    .empty (empty)
  );

  stt_ctx_store #(.ID_W(ID_W), .ADDR_W(ADDR_W), .CMD_W(CMD_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (req_fire),
    .wr_slot  (wr_slot),
    .wr_id    (req_id),
    .wr_addr  (req_addr),
    .wr_cmd   (req_cmd),
    .clr_en   (retire),
    .clr_slot (rd_slot),
    .rd_slot  (rd_slot),
    .rd_id    (rd_id),
    .rd_addr  (rd_addr),
    .rd_cmd   (rd_cmd),
    .busy     (busy)
  );

  stt_cpl_stage #(.ID_W(ID_W), .ADDR_W(ADDR_W), .CMD_W(CMD_W), .DATA_W(DATA_W)) u_cpl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_fire   (rsp_fire),
    .in_hit    (match),
    .in_err    (err_now),
    .in_id     (rd_id),
    .in_addr   (rd_addr),
    .in_cmd    (rd_cmd),
    .in_data   (rsp_data),
    .in_ready  (rsp_ready),
    .out_ready (cpl_ready),
    .out_valid (cpl_valid),
    .out_id    (cpl_id),
    .out_addr  (cpl_addr),
    .out_cmd   (cpl_cmd),
    .out_data  (cpl_data),
    .out_err   (err_code)
  );

  // R6: a tag-mode completion names the tag of the response that caused it
  p_tag_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && tag_mode) |=> (!cpl_valid || (cpl_id == $past(rsp_id))));

  // R3: an ordered completion carries the returned data
  p_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (!cpl_valid || (cpl_data == $past(rsp_data))));

  // R9: no response is taken while a completion is stalled
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |-> !rsp_ready);

endmodule

// File: tb/stt_tracker_tb_top.sv
`timescale 1ns/1ps
module stt_tracker_tb_top;

  localparam int ID_W = 3, ADDR_W = 16, CMD_W = 2, DATA_W = 32, MAXO = 6;

  logic clk, rst_n, tag_mode;
  logic req_valid, req_ready, rsp_valid, rsp_ready, cpl_valid, cpl_ready;
  logic [ID_W-1:0] req_id, rsp_id, cpl_id;
  logic [ADDR_W-1:0] req_addr, cpl_addr;
  logic [CMD_W-1:0] req_cmd, cpl_cmd;
  logic [DATA_W-1:0] rsp_data, cpl_data;
  logic [1:0] err_code;

  int vectors = 0;
  int fails   = 0;

  stt_tracker #(.ID_W(ID_W), .ADDR_W(ADDR_W), .CMD_W(CMD_W), .DATA_W(DATA_W), .MAX_OUT(MAXO)) dut_i (
    .clk(clk), .rst_n(rst_n), .tag_mode(tag_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id), .req_addr(req_addr), .req_cmd(req_cmd),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id), .rsp_data(rsp_data),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_id(cpl_id), .cpl_addr(cpl_addr),
    .cpl_cmd(cpl_cmd), .cpl_data(cpl_data), .err_code(err_code)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // reference model state
  typedef struct { logic [ID_W-1:0] id; logic [ADDR_W-1:0] addr; logic [CMD_W-1:0] cmd; } ent_t;
  ent_t oq[$];
  bit   tbusy [8];
  logic [ADDR_W-1:0] taddr [8];
  logic [CMD_W-1:0]  tcmd  [8];
  int   cnt = 0;
  bit   e_cv = 0;
  logic [1:0] e_err = 2'b00;
  logic [ID_W-1:0] e_id;
  logic [ADDR_W-1:0] e_addr;
  logic [CMD_W-1:0] e_cmd;
  logic [DATA_W-1:0] e_data;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  task automatic set_req(bit v, int id, int addr, int cmd);
    req_valid = v; req_id = ID_W'(id); req_addr = ADDR_W'(addr); req_cmd = CMD_W'(cmd);
  endtask

  task automatic set_rsp(bit v, int id, logic [DATA_W-1:0] d);
    rsp_valid = v; rsp_id = ID_W'(id); rsp_data = d;
  endtask

  // one clock: check readies, apply edge to model, check outputs
  task automatic tick(string tag);
    bit e_rq, e_rs, rf, sf, pres, mt;
    ent_t h;
    #1;
    e_rq = (cnt < MAXO) && !(tag_mode && tbusy[req_id]);
    e_rs = !e_cv || cpl_ready;
    chk(tag, "req_ready", 64'(req_ready), 64'(e_rq));
    chk(tag, "rsp_ready", 64'(rsp_ready), 64'(e_rs));
    rf = req_valid && e_rq;
    sf = rsp_valid && e_rs;
    @(posedge clk);
    if (sf) begin
      if (tag_mode) begin
        pres = tbusy[rsp_id]; mt = pres;
        if (pres) begin
          e_id = rsp_id; e_addr = taddr[rsp_id]; e_cmd = tcmd[rsp_id];
          tbusy[rsp_id] = 0;
        end
      end else begin
        pres = (oq.size() != 0); mt = 0;
        if (pres) begin
          h = oq.pop_front();
          mt = (h.id == rsp_id);
          e_id = h.id; e_addr = h.addr; e_cmd = h.cmd;
        end
      end
      if (pres) cnt--;
      e_cv  = mt;
      e_data = rsp_data;
      e_err = !pres ? 2'b01 : (!mt ? 2'b10 : 2'b00);
    end else begin
      if (cpl_ready) e_cv = 0;
      e_err = 2'b00;
    end
    if (rf) begin
      h.id = req_id; h.addr = req_addr; h.cmd = req_cmd;
      if (tag_mode) begin
        tbusy[req_id] = 1; taddr[req_id] = req_addr; tcmd[req_id] = req_cmd;
      end else oq.push_back(h);
      cnt++;
    end
    @(negedge clk);
    chk(tag, "cpl_valid", 64'(cpl_valid), 64'(e_cv));
    chk(tag, "err_code", 64'(err_code), 64'(e_err));
    if (e_cv) begin
      chk(tag, "cpl_id", 64'(cpl_id), 64'(e_id));
      chk(tag, "cpl_addr", 64'(cpl_addr), 64'(e_addr));
      chk(tag, "cpl_cmd", 64'(cpl_cmd), 64'(e_cmd));
      chk(tag, "cpl_data", 64'(cpl_data), 64'(e_data));
    end
  endtask

  task automatic idle();
    set_req(0, 0, 0, 0);
    set_rsp(0, 0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; tag_mode = 1'b0; cpl_ready = 1'b1;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "req_ready", 64'(req_ready), 64'd1);
    chk("R1", "rsp_ready", 64'(rsp_ready), 64'd1);
    chk("R1", "cpl_valid", 64'(cpl_valid), 64'd0);
    chk("R1", "err_code", 64'(err_code), 64'd0);

    // R3 ordered: three requests, in-order responses
    for (int i = 0; i < 3; i++) begin set_req(1, i, 16'h100 + i, i); tick("R3"); end
    idle();
    for (int i = 0; i < 3; i++) begin set_rsp(1, i, 32'hA000_0000 + i); tick("R3"); end
    idle(); tick("R3");

    // R2 limit: fill to MAX_OUT and keep offering
    for (int i = 0; i < MAXO + 2; i++) begin set_req(1, i, 16'h200 + i, 1); tick("R2"); end
    idle();
    for (int i = 0; i < MAXO; i++) begin set_rsp(1, i, 32'hB000_0000 + i); tick("R2"); end
    idle(); tick("R2");

    // R4 order violation
    set_req(1, 4, 16'h344, 2); tick("R4");
    set_req(1, 5, 16'h355, 3); tick("R4");
    idle();
    set_rsp(1, 5, 32'hC5); tick("R4");
    set_rsp(1, 5, 32'hC6); tick("R4");
    idle(); tick("R4");

    // R5 orphan on empty ordered link
    set_rsp(1, 2, 32'hDEAD); tick("R5");
    idle(); tick("R5");

    // R8 same-edge request and response, ordered
    set_req(1, 1, 16'h411, 1); tick("R8");
    set_req(1, 2, 16'h422, 2); set_rsp(1, 1, 32'h81); tick("R8");
    set_req(1, 3, 16'h433, 3); set_rsp(1, 2, 32'h82); tick("R8");
    idle(); set_rsp(1, 3, 32'h83); tick("R8");
    idle(); tick("R8");

    // R9 completion back-pressure
    set_req(1, 6, 16'h566, 1); tick("R9");
    set_req(1, 7, 16'h577, 2); tick("R9");
    idle(); cpl_ready = 0;
    set_rsp(1, 6, 32'h96); tick("R9");
    set_rsp(1, 7, 32'h97); tick("R9"); tick("R9"); tick("R9");
    cpl_ready = 1; tick("R9");
    idle(); tick("R9");

    // ordered random mix, mostly correct tags
    for (int n = 0; n < 150; n++) begin
      set_req($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 65535), $urandom_range(0, 3));
      set_rsp($urandom_range(0, 2) == 0, (oq.size() != 0 && $urandom_range(0, 5) != 0) ? int'(oq[0].id) : $urandom_range(0, 7),
              $urandom());
      cpl_ready = ($urandom_range(0, 3) != 0);
      tick("R8");
    end
    idle(); cpl_ready = 1;
    while (oq.size() != 0) begin set_rsp(1, oq[0].id, $urandom()); tick("R3"); end
    idle(); tick("R3");

    // tag mode
    tag_mode = 1'b1;
    // R6 out-of-order returns
    set_req(1, 1, 16'h611, 1); tick("R6");
    set_req(1, 3, 16'h633, 2); tick("R6");
    set_req(1, 6, 16'h666, 3); tick("R6");
    idle();
    set_rsp(1, 6, 32'h66); tick("R6");
    set_rsp(1, 1, 32'h11); tick("R6");
    set_rsp(1, 3, 32'h33); tick("R6");
    idle(); tick("R6");

    // R7 tag reuse stall
    set_req(1, 2, 16'h722, 1); tick("R7");
    set_req(1, 2, 16'h7AA, 2); tick("R7"); tick("R7");
    set_rsp(1, 2, 32'h72); tick("R7");
    set_rsp(0, 0, '0); tick("R7");
    idle(); set_rsp(1, 2, 32'h73); tick("R7");
    idle(); tick("R7");

    // R5 unknown tag in tag mode
    set_rsp(1, 7, 32'hBAD); tick("R5");
    idle(); tick("R5");

    // tag-mode random mix
    for (int n = 0; n < 300; n++) begin
      set_req($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 65535), $urandom_range(0, 3));
      set_rsp($urandom_range(0, 1), $urandom_range(0, 7), $urandom());
      cpl_ready = ($urandom_range(0, 3) != 0);
      tick("R6");
    end
    idle(); cpl_ready = 1; tick("R6");

    summary();
    $finish;
  end

endmodule